// File: doc/BRIEF.md
# Factory Information Page Controller

This block holds a 1024-byte non-volatile information page for factory data such as serial numbers and calibration constants. The page sits on the data-side bus in a fixed window. The CPU may read any single byte of it. Writes always program one whole 16-bit word. An erase always clears the entire page. Program and erase are gated by an enable input that only the serial debug port drives. Because of this, code running on the CPU cannot change the page unless the debug port has first opened it.

Storage behaves as flash. An erased cell reads as ones, and programming can only clear bits. Each program or erase keeps the block busy for a fixed number of cycles. While it is busy, accesses to the page and to the command register are stalled. A control register starts the erase, and a status register reports three things: busy, a sticky error and the enable state. Any refused program or erase sets the error. Reading the status register clears it.

Top module: `infopage_ctrl`

## Requirements
- R1: After reset every page byte reads 0xFF, and the status register reads busy=0 and error=0. Status bit 0 is busy, bit 1 is error and bit 2 mirrors the enable input; bits 7:3 read 0.
- R2: The page is decoded at 0x5000..0x53FF. A read returns byte lane addr[0] of the word at addr[9:1]: lane 0 is bits 7:0 and lane 1 is bits 15:8. Addresses outside the page and the registers read 0x00.
- R3: A word write (bus_word=1) into the page with the enable high stores old AND new at word index addr[9:1]; addr[0] is ignored.
- R4: A byte-sized write (bus_word=0) into the page never changes storage and sets the error flag.
- R5: Writing the control register at 0x4FF0 with data bit 0 = 1 and the enable high sets every page byte to 0xFF. A control write with bit 0 = 0 does nothing.
- R6: While the enable is low, page word writes and erase commands leave the page unchanged and set the error flag.
- R7: The error flag stays set until the status register at 0x4FF2 is read. The read that clears it still returns error=1, and the next read returns error=0.
- R8: Status busy reads 1 for exactly PROG_CYCLES (default 4) cycles after an accepted program, and for exactly ERASE_CYCLES (default 8) cycles after an accepted erase.
- R9: While busy, page and control accesses hold bus_ready low until busy ends. Status reads are never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | Write size: 1 = word, 0 = byte |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 8 | Read byte (combinational) |
| bus_ready | output | 1 | Access completes at this edge when high |
| dbg_pe_en | input | 1 | Program/erase enable from the debug port |

## Verification
A stored word that is corrupted shows up on the next byte read of either lane, and the bench reads both lanes after every change. A busy counter that is off by a count shows up as one stall cycle too many or too few on the page read that follows straight after a program or erase. The same error shows in the number of consecutive status reads that report busy, so it is visible within that operation. An error flag that fails to set, clear or stick shows up on the very next status read.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int unsigned IPG_WORD_W = 16;
  localparam int unsigned IPG_BYTE_W = 8;
  localparam int unsigned IPG_LANES  = IPG_WORD_W / IPG_BYTE_W;
  localparam int unsigned IPG_LANE_W = $clog2(IPG_LANES);

  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_EN   = 2;

  typedef logic [IPG_WORD_W-1:0] word_t;
  typedef logic [IPG_BYTE_W-1:0] byte_t;

  // Flash programming can only pull bits low.
  function automatic word_t prog_merge(word_t stored, word_t incoming);
    return stored & incoming;
  endfunction

  function automatic byte_t lane_pick(word_t w, logic [IPG_LANE_W-1:0] lane);
    return byte_t'(w >> (IPG_BYTE_W * lane));
  endfunction

  function automatic byte_t status_pack(logic busy, logic err, logic en);
    byte_t s;
    s = '0;
    s[ST_BUSY] = busy;
    s[ST_ERR]  = err;
    s[ST_EN]   = en;
    return s;
  endfunction
endpackage

// File: rtl/ipg_decode.sv
module ipg_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_BYTES = 1024,
  parameter logic [ADDR_W-1:0] PAGE_BASE = 16'h5000,
  parameter logic [ADDR_W-1:0] CSR_BASE  = 16'h4FF0
) (
  input  logic              sel,
  input  logic              we,
  input  logic              word_sz,
  input  logic [ADDR_W-1:0] addr,
  input  logic              erase_bit,
  input  logic              busy,
  input  logic              pe_en,
  output logic              page_hit,
  output logic              stat_hit,
  output logic              ready,
  output logic              prog_go,
  output logic              erase_go,
  output logic              deny,
  output logic              stat_rd
);
  localparam int unsigned PAGE_AW = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = CSR_BASE;
  localparam logic [ADDR_W-1:0] STAT_ADDR = CSR_BASE + ADDR_W'(2);

  logic ctrl_hit, acc, wr_page_w, wr_page_b, erase_req;

  always_comb begin
    page_hit  = (addr[ADDR_W-1:PAGE_AW] == PAGE_BASE[ADDR_W-1:PAGE_AW]);
    ctrl_hit  = (addr == CTRL_ADDR);
    stat_hit  = (addr == STAT_ADDR);
    ready     = !(busy && (page_hit || ctrl_hit));
    acc       = sel && ready;
    wr_page_w = acc && we && page_hit && word_sz;
    wr_page_b = acc && we && page_hit && !word_sz;
    erase_req = acc && we && ctrl_hit && erase_bit;
    prog_go   = wr_page_w && pe_en;
    erase_go  = erase_req && pe_en;
    deny      = wr_page_b || ((wr_page_w || erase_req) && !pe_en);
    stat_rd   = acc && !we && stat_hit;
  end
endmodule

// File: rtl/ipg_seq.sv
module ipg_seq #(
  parameter int unsigned AW           = 9,
  parameter int unsigned PROG_CYCLES  = 4,
  parameter int unsigned ERASE_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prog_go,
  input  logic                  erase_go,
  input  logic [AW-1:0]         go_addr,
  input  ipg_pkg::word_t        go_data,
  output logic                  busy,
  output logic                  commit_prog,
  output logic                  commit_erase,
  output logic [AW-1:0]         op_addr,
  output ipg_pkg::word_t        op_data
);
  import ipg_pkg::*;
  localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {OP_IDLE, OP_PROG, OP_ERASE} op_e;

  logic [CW-1:0] cnt;
  op_e           op;
  logic          last;

  assign busy         = (cnt != '0);
  assign last         = (cnt == CW'(1));
  assign commit_prog  = last && (op == OP_PROG);
  assign commit_erase = last && (op == OP_ERASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      op      <= OP_IDLE;
      op_addr <= '0;
      op_data <= '1;
    end else if (prog_go) begin
      cnt     <= CW'(PROG_CYCLES);
      op      <= OP_PROG;
      op_addr <= go_addr;
      op_data <= go_data;
    end else if (erase_go) begin
      cnt     <= CW'(ERASE_CYCLES);
      op      <= OP_ERASE;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (last) op <= OP_IDLE;
    end
  end
endmodule

// File: rtl/ipg_array.sv
module ipg_array #(
  parameter int unsigned WORDS = 512,
  parameter int unsigned AW    = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit_prog,
  input  logic           commit_erase,
  input  logic [AW-1:0]  wr_addr,
  input  ipg_pkg::word_t wr_data,
  input  logic [AW-1:0]  rd_addr,
  output ipg_pkg::word_t rd_word
);
  import ipg_pkg::*;
  word_t mem [WORDS];

  assign rd_word = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '1;
    end else if (commit_erase) begin
      for (int i = 0; i < int'(WORDS); i++) mem[i] <= '1;
    end else if (commit_prog) begin
      mem[wr_addr] <= prog_merge(mem[wr_addr], wr_data);
    end
  end
endmodule

// File: rtl/infopage_ctrl.sv
module infopage_ctrl #(
  parameter int unsigned PAGE_BYTES   = 1024,
  parameter logic [15:0] PAGE_BASE    = 16'h5000,
  parameter logic [15:0] CSR_BASE     = 16'h4FF0,
  parameter int unsigned PROG_CYCLES  = 4,
  parameter int unsigned ERASE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic        bus_word,
  input  logic [15:0] bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        bus_ready,
  input  logic        dbg_pe_en
);
  import ipg_pkg::*;
  localparam int unsigned WORDS = PAGE_BYTES / IPG_LANES;
  localparam int unsigned AW    = $clog2(WORDS);

  logic          page_hit, stat_hit;
  logic          prog_go, erase_go, deny, stat_rd;
  logic          busy, commit_prog, commit_erase;
  logic [AW-1:0] op_addr, word_idx;
  word_t         op_data, rd_word;
  logic          err_q;
  logic [IPG_LANE_W-1:0] lane;

  assign word_idx = bus_addr[AW+IPG_LANE_W-1:IPG_LANE_W];
  assign lane     = bus_addr[IPG_LANE_W-1:0];

  ipg_decode #(
    .ADDR_W(16), .PAGE_BYTES(PAGE_BYTES), .PAGE_BASE(PAGE_BASE), .CSR_BASE(CSR_BASE)
  ) u_dec (
    .sel(bus_sel), .we(bus_we), .word_sz(bus_word), .addr(bus_addr),
    .erase_bit(bus_wdata[0]), .busy(busy), .pe_en(dbg_pe_en),
    .page_hit(page_hit), .stat_hit(stat_hit), .ready(bus_ready),
    .prog_go(prog_go), .erase_go(erase_go), .deny(deny), .stat_rd(stat_rd)
  );

  ipg_seq #(
    .AW(AW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
    .go_addr(word_idx), .go_data(bus_wdata), .busy(busy),
    .commit_prog(commit_prog), .commit_erase(commit_erase),
    .op_addr(op_addr), .op_data(op_data)
  );

  ipg_array #(.WORDS(WORDS), .AW(AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit_prog(commit_prog), .commit_erase(commit_erase),
    .wr_addr(op_addr), .wr_data(op_data), .rd_addr(word_idx), .rd_word(rd_word)
  );

  // Sticky error: a refused request sets it, a status read clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (deny)    err_q <= 1'b1;
    else if (stat_rd) err_q <= 1'b0;
  end

  always_comb begin
    if (stat_hit)      bus_rdata = status_pack(busy, err_q, dbg_pe_en);
    else if (page_hit) bus_rdata = lane_pick(rd_word, lane);
    else               bus_rdata = '0;
  end
endmodule

// File: rtl/ipg_checker.sv
module ipg_checker #(
  parameter logic [15:0] PAGE_BASE = 16'h5000,
  parameter logic [15:0] CSR_BASE  = 16'h4FF0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [15:0] bus_addr,
  input logic        bus_ready,
  input logic        busy,
  input logic        prog_go,
  input logic        erase_go,
  input logic        commit_prog,
  input logic        commit_erase,
  input logic        deny,
  input logic        stat_rd,
  input logic        err_q
);
  logic in_page;
  assign in_page = (bus_addr[15:10] == PAGE_BASE[15:10]);

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_sel && in_page) |-> !bus_ready); // R9
  AST_STAT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == CSR_BASE + 16'd2) |-> bus_ready); // R9
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go || erase_go) |=> busy); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_prog || commit_erase) |=> !busy); // R8
  AST_ERR_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    deny |=> err_q); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !deny) |=> !err_q); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !stat_rd) |=> err_q); // R7
  AST_NO_WRITE_READ_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |-> !(prog_go || erase_go)); // R3
endmodule

bind infopage_ctrl ipg_checker #(.PAGE_BASE(PAGE_BASE), .CSR_BASE(CSR_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_ready(bus_ready), .busy(busy), .prog_go(prog_go), .erase_go(erase_go),
  .commit_prog(commit_prog), .commit_erase(commit_erase), .deny(deny),
  .stat_rd(stat_rd), .err_q(err_q)
);

// File: tb/infopage_ctrl_bench.sv
`timescale 1ns/1ps
module infopage_ctrl_bench;
  localparam int PROG_N  = 4;
  localparam int ERASE_N = 8;
  localparam logic [15:0] CTRL = 16'h4FF0;
  localparam logic [15:0] STAT = 16'h4FF2;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0, bus_word = 1, dbg_pe_en = 0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_ready;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  infopage_ctrl u_infopage_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .dbg_pe_en(dbg_pe_en)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic word, input logic [15:0] a,
                      input logic [15:0] d, output logic [7:0] rd, output int stalls);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_word = word; bus_addr = a; bus_wdata = d;
    stalls = 0; rd = '0;
    while (1) begin
      #1;
      if (bus_ready) begin
        rd = bus_rdata;
        @(posedge clk);
        break;
      end
      stalls++;
      @(negedge clk);
    end
    #1 bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd8(input logic [15:0] a, output logic [7:0] v);
    int s;
    xfer(1'b0, 1'b1, a, 16'h0, v, s);
  endtask

  task automatic wr(input logic word, input logic [15:0] a, input logic [15:0] d);
    logic [7:0] v; int s;
    xfer(1'b1, word, a, d, v, s);
  endtask

  // Counts consecutive status reads that show busy.
  task automatic busy_span(output int n);
    logic [7:0] v;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      rd8(STAT, v);
      if (!v[0]) break;
      n++;
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd8(STAT, v);      chk("R1 status after reset", v, 8'h00);
    rd8(16'h5000, v);  chk("R1 first byte erased", v, 8'hFF);
    rd8(16'h53FF, v);  chk("R1 last byte erased", v, 8'hFF);
  endtask

  task automatic t_decode;
    logic [7:0] v;
    rd8(16'h5400, v);  chk("R2 above window reads 0", v, 8'h00);
    rd8(16'h4FFF, v);  chk("R2 below window reads 0", v, 8'h00);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    dbg_pe_en = 0;
    wr(1'b1, 16'h5010, 16'h1234);
    rd8(16'h5010, v);  chk("R6 disabled write lane0 unchanged", v, 8'hFF);
    rd8(16'h5011, v);  chk("R6 disabled write lane1 unchanged", v, 8'hFF);
    rd8(STAT, v);      chk("R7 error seen on first status read", v, 8'h02);
    rd8(STAT, v);      chk("R7 error cleared by read", v, 8'h00);
    wr(1'b1, CTRL, 16'h0001);
    rd8(STAT, v);      chk("R6 disabled erase sets error, not busy", v, 8'h02);
    rd8(STAT, v);      chk("R7 error cleared again", v, 8'h00);
  endtask

  task automatic t_prog;
    logic [7:0] v; int s, n;
    dbg_pe_en = 1;
    wr(1'b1, 16'h5020, 16'hA55A);
    xfer(1'b0, 1'b1, 16'h5020, 16'h0, v, s);
    chk("R9 page read stalls for program", s, PROG_N);
    chk("R3 programmed lane0", v, 8'h5A);
    rd8(16'h5021, v);  chk("R2 lane1 is high byte", v, 8'hA5);
    wr(1'b1, 16'h5020, 16'h0FF0);
    busy_span(n);      chk("R8 program busy span", n, PROG_N);
    rd8(STAT, v);      chk("R1 status idle with enable bit", v, 8'h04);
    rd8(16'h5020, v);  chk("R3 AND merge lane0", v, 8'h50);
    rd8(16'h5021, v);  chk("R3 AND merge lane1", v, 8'h05);
    wr(1'b1, 16'h5031, 16'h00FF);
    busy_span(n);
    rd8(16'h5030, v);  chk("R3 odd address uses word index lane0", v, 8'hFF);
    rd8(16'h5031, v);  chk("R3 odd address uses word index lane1", v, 8'h00);
    wr(1'b1, 16'h53FE, 16'h1357);
    busy_span(n);
    rd8(16'h53FF, v);  chk("R3 last word lane1", v, 8'h13);
  endtask

  task automatic t_byte;
    logic [7:0] v;
    wr(1'b0, 16'h5040, 16'h0000);
    rd8(STAT, v);      chk("R4 byte write sets error, no busy", v, 8'h06);
    rd8(16'h5040, v);  chk("R4 byte write ignored", v, 8'hFF);
    rd8(STAT, v);      chk("R7 cleared after byte error", v, 8'h04);
  endtask

  task automatic t_erase;
    logic [7:0] v; int s, n;
    wr(1'b1, CTRL, 16'h0000);
    rd8(STAT, v);      chk("R5 control bit0=0 does nothing", v, 8'h04);
    rd8(16'h5020, v);  chk("R5 no erase on bit0=0", v, 8'h50);
    wr(1'b1, CTRL, 16'h0001);
    xfer(1'b0, 1'b1, STAT, 16'h0, v, s);
    chk("R9 status read not stalled", s, 0);
    chk("R8 busy during erase", v, 8'h05);
    busy_span(n);      chk("R8 erase busy span", n, ERASE_N - 1);
    rd8(16'h5020, v);  chk("R5 erased lane0", v, 8'hFF);
    rd8(16'h5031, v);  chk("R5 erased odd byte", v, 8'hFF);
    rd8(16'h53FF, v);  chk("R5 erased last byte", v, 8'hFF);
    wr(1'b1, CTRL, 16'h0001);
    xfer(1'b0, 1'b1, 16'h5100, 16'h0, v, s);
    chk("R9 page read stalls for erase", s, ERASE_N);
    chk("R5 read after erase", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_decode();
    t_gate();
    t_prog();
    t_byte();
    t_erase();
    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end
endmodule